// File: doc/BRIEF.md
# Duty-Cycle Code Interpolator

This block widens the resolution of a coarse 16-bit converter by two bits through time averaging. An 18-bit code is split into a coarse value C and a 2-bit fraction. The 16-bit output stream toggles between C and C+1. The share of time spent at C+1 (none, a quarter, a half or three quarters) carries the two extra bits, and a downstream analog filter averages them into the fine level.

An interpolation period is four phases long. The phase counter advances on each pulse of `rateTick`, which the surrounding logic derives from a local clock so that one full period runs at the wanted rate (nominally 10 kHz). Within a period, the C+1 phases are spread as evenly as possible. Codes are written with `codeLoad`, but a new code only takes effect at the start of the next period, so every period is built from a single code. At the highest coarse value the upper code saturates instead of wrapping to zero.

Top module: `fine_code_interp`

## Requirements
- R1: The input code is split as coarse = codeIn[17:2] and fraction = codeIn[1:0]. The output is always either the coarse value or the coarse value plus one.
- R2: With fraction 00 the output stays at the coarse value C in all four phases.
- R3: The output is C+1 in the following phases (numbered 0 to 3): phase 3 only for fraction 01, phases 1 and 3 for fraction 10, and phases 1, 2 and 3 for fraction 11. Phase 0 always outputs C.
- R4: The phase advances by one on each cycle with rateTick high and wraps from 3 to 0. On cycles without rateTick the output holds its value.
- R5: When the coarse value is 0xFFFF, the value C+1 is replaced by 0xFFFF, so the output never wraps to 0.
- R6: A code loaded on any cycle other than a wrap tick leaves the output unchanged in the current period. The most recent load is applied at the next wrap tick (the rateTick in phase 3).
- R7: A code loaded on the same cycle as a wrap tick is applied in the period that begins on that tick.
- R8: After reset the phase is 0 and the output equals RESET_CODE[17:2]. With the default RESET_CODE of 0, the output is 0.
- R9: Code 4092 gives a constant 1023. Code 4094 gives 1023, 1024, 1023, 1024. Code 4096 gives a constant 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| codeIn | input | 18 | Fine code to be interpolated |
| codeLoad | input | 1 | Captures codeIn on this cycle |
| rateTick | input | 1 | Advances the interpolation phase by one |
| coarseOut | output | 16 | Code presented to the coarse converter |

## Verification
The bench sweeps all four fractions over coarse values at the bottom, at a carry boundary, at an alternating bit pattern and at the top of the range. Fraction 00 against the nonzero fractions separates a constant output from the toggling patterns. The phase-by-phase comparison distinguishes an evenly spread pattern from a bunched one. Coarse 0xFFFF exposes a missing clamp. Loads are issued in mid-period, twice in one period, and on the wrap tick, which separates deferred application, last-write-wins and same-cycle bypass. Idle cycles between ticks check that the output holds, and the fixed codes 4092, 4094 and 4096 are checked against literal sequences.

// File: rtl/dither_pkg.sv
package dither_pkg;
  // Strobes sent from the phase control to the code datapath
  typedef struct packed {
    logic advance;      // a rate tick on this cycle
    logic periodStart;  // tick that closes phase last and opens a new period
  } ctrlBus_t;
endpackage

// File: rtl/dither_ctrl.sv
module dither_ctrl
  import dither_pkg::*;
#(
  parameter int PH_W = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            rateTick,
  output logic [PH_W-1:0] phase,
  output ctrlBus_t        bus
);
  localparam logic [PH_W-1:0] LAST_PHASE = '1;

  always_ff @(posedge clk) begin
    if (!rstN)         phase <= '0;
    else if (rateTick) phase <= phase + 1'b1;
  end

  always_comb begin
    bus.advance     = rateTick;
    bus.periodStart = rateTick && (phase == LAST_PHASE);
  end
endmodule

// File: rtl/dither_pattern.sv
module dither_pattern #(
  parameter int PH_W = 2
) (
  input  logic [PH_W-1:0] phase,
  input  logic [PH_W-1:0] frac,
  output logic            useUpper
);
  logic [PH_W-1:0] revPhase;
  logic [PH_W:0]   sum;

  // bit-reversed phase orders the upper slots so they spread evenly
  for (genvar i = 0; i < PH_W; i++) begin : g_rev
    assign revPhase[i] = phase[PH_W-1-i];
  end

  // upper code when revPhase >= 2**PH_W - frac
  assign sum      = {1'b0, revPhase} + {1'b0, frac};
  assign useUpper = sum[PH_W];
endmodule

// File: rtl/dither_dp.sv
module dither_dp
  import dither_pkg::*;
#(
  parameter int                CODE_W     = 18,
  parameter int                PH_W       = 2,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlBus_t               bus,
  input  logic [PH_W-1:0]        phase,
  input  logic [CODE_W-1:0]      codeIn,
  input  logic                   codeLoad,
  output logic [CODE_W-PH_W-1:0] coarseOut
);
  localparam int COARSE_W = CODE_W - PH_W;

  logic [CODE_W-1:0]   stagedCode;
  logic [CODE_W-1:0]   activeCode;
  logic [COARSE_W-1:0] base;
  logic [PH_W-1:0]     frac;
  logic                useUpper;
  logic                atTop;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stagedCode <= RESET_CODE;
      activeCode <= RESET_CODE;
    end else begin
      if (codeLoad)        stagedCode <= codeIn;
      if (bus.periodStart) activeCode <= codeLoad ? codeIn : stagedCode;
    end
  end

  assign base  = activeCode[CODE_W-1:PH_W];
  assign frac  = activeCode[PH_W-1:0];
  assign atTop = &base;

  dither_pattern #(.PH_W(PH_W)) i_pattern (
    .phase    (phase),
    .frac     (frac),
    .useUpper (useUpper)
  );

  assign coarseOut = (useUpper && !atTop) ? base + 1'b1 : base;
endmodule

// File: rtl/fine_code_interp.sv
module fine_code_interp
  import dither_pkg::*;
#(
  parameter int                CODE_W     = 18,
  parameter int                FRAC_W     = 2,
  parameter logic [CODE_W-1:0] RESET_CODE = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CODE_W-1:0]        codeIn,
  input  logic                     codeLoad,
  input  logic                     rateTick,
  output logic [CODE_W-FRAC_W-1:0] coarseOut
);
  ctrlBus_t          ctrlBus;
  logic [FRAC_W-1:0] phase;

  dither_ctrl #(.PH_W(FRAC_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rateTick (rateTick),
    .phase    (phase),
    .bus      (ctrlBus)
  );

  dither_dp #(
    .CODE_W     (CODE_W),
    .PH_W       (FRAC_W),
    .RESET_CODE (RESET_CODE)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .bus       (ctrlBus),
    .phase     (phase),
    .codeIn    (codeIn),
    .codeLoad  (codeLoad),
    .coarseOut (coarseOut)
  );
endmodule

// File: rtl/dither_chk.sv
module dither_chk
  import dither_pkg::*;
#(
  parameter int CODE_W = 18,
  parameter int FRAC_W = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [CODE_W-1:0]        codeIn,
  input logic                     codeLoad,
  input logic                     rateTick,
  input logic [CODE_W-FRAC_W-1:0] coarseOut,
  input logic [FRAC_W-1:0]        phase,
  input ctrlBus_t                 ctrlBus
);
  localparam logic [FRAC_W-1:0] ONE = 1;

  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
    !rateTick |=> $stable(coarseOut)); // R4

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    rateTick |=> ((phase - $past(phase)) == ONE)); // R4

  AST_WRAP_LOAD_APPLIES: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBus.periodStart && codeLoad) |=>
      (coarseOut == $past(codeIn[CODE_W-1:FRAC_W]))); // R7

  AST_ADJACENT_STEPS: assert property (@(posedge clk) disable iff (!rstN)
    (rateTick && !ctrlBus.periodStart) |=>
      (({1'b0, coarseOut} == {1'b0, $past(coarseOut)} + 1) ||
       ({1'b0, $past(coarseOut)} == {1'b0, coarseOut} + 1) ||
       (coarseOut == $past(coarseOut)))); // R5
endmodule

bind fine_code_interp dither_chk #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .codeIn    (codeIn),
  .codeLoad  (codeLoad),
  .rateTick  (rateTick),
  .coarseOut (coarseOut),
  .phase     (phase),
  .ctrlBus   (ctrlBus)
);

// File: tb/test_fine_code_interp.sv
`timescale 1ns/1ps
module test_fine_code_interp;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [17:0] codeIn = '0;
  logic        codeLoad = 1'b0;
  logic        rateTick = 1'b0;
  logic [15:0] coarseOut;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // bench model state, built from the requirements
  int          mPhase = 0;
  logic [17:0] mStaged = '0;
  logic [17:0] mActive = '0;

  always #2 clk = ~clk;

  fine_code_interp i_fine_code_interp (
    .clk(clk), .rstN(rstN), .codeIn(codeIn), .codeLoad(codeLoad),
    .rateTick(rateTick), .coarseOut(coarseOut)
  );

  function automatic logic [15:0] expOut(input logic [17:0] a, input int p);
    logic [15:0] c;
    logic [1:0]  f;
    bit hi;
    c = a[17:2];
    f = a[1:0];
    hi = (f == 2'd1 && p == 3) ||
         (f == 2'd2 && (p == 1 || p == 3)) ||
         (f == 2'd3 && p != 0);
    return (hi && c != 16'hFFFF) ? c + 16'd1 : c;
  endfunction

  task automatic check(input logic [15:0] exp, input string tag);
    vectors++;
    if (coarseOut !== exp) begin
      fails++;
      $display("FAIL %s: coarseOut=%0h expected=%0h (phase %0d)", tag, coarseOut, exp, mPhase);
    end
  endtask

  task automatic step(input logic ld, input logic [17:0] code, input logic tk, input string tag);
    codeIn = code;
    codeLoad = ld;
    rateTick = tk;
    @(posedge clk);
    if (tk) begin
      if (mPhase == 3) mActive = ld ? code : mStaged;
      mPhase = (mPhase + 1) % 4;
    end
    if (ld) mStaged = code;
    @(negedge clk);
    codeLoad = 1'b0;
    rateTick = 1'b0;
    check(expOut(mActive, mPhase), tag);
  endtask

  // bring a code into the active slot, then record one period literally
  task automatic watchPeriod(input logic [17:0] code, input logic [15:0] e0,
                             input logic [15:0] e1, input logic [15:0] e2, input logic [15:0] e3);
    step(1'b1, code, 1'b0, "R6");
    while (mPhase != 3) step(1'b0, '0, 1'b1, "R4");
    step(1'b0, '0, 1'b1, "R9"); check(e0, "R9");
    step(1'b0, '0, 1'b1, "R9"); check(e1, "R9");
    step(1'b0, '0, 1'b1, "R9"); check(e2, "R9");
    step(1'b0, '0, 1'b1, "R9"); check(e3, "R9");
  endtask

  initial begin
    logic [15:0] coarseList [7];
    coarseList = '{16'h0000, 16'h0001, 16'd1023, 16'h7FFF, 16'hA5A5, 16'hFFFE, 16'hFFFF};
    repeat (3) @(negedge clk);
    check(16'h0000, "R8");          // reset output
    rstN = 1'b1;
    step(1'b0, '0, 1'b0, "R8");

    // R9: literal examples
    watchPeriod(18'd4092, 16'd1023, 16'd1023, 16'd1023, 16'd1023);
    watchPeriod(18'd4094, 16'd1023, 16'd1024, 16'd1023, 16'd1024);
    watchPeriod(18'd4096, 16'd1024, 16'd1024, 16'd1024, 16'd1024);
    // R1: field split of a mixed bit pattern, fraction 01 upper in phase 3
    watchPeriod(18'h2AAA9, 16'hAAAA, 16'hAAAA, 16'hAAAA, 16'hAAAB);

    // sweep coarse values with every fraction
    for (int ci = 0; ci < 7; ci++) begin
      for (int f = 0; f < 4; f++) begin
        logic [17:0] code;
        string tag;
        code = {coarseList[ci], f[1:0]};
        tag = (coarseList[ci] == 16'hFFFF) ? "R5" : (f == 0) ? "R2" : "R3";
        step(1'b0, '0, 1'b1, "R4");                    // misalign phase
        step(1'b1, code ^ 18'h00007, 1'b0, "R6");      // mid-period load, no effect
        step(1'b1, code, 1'b0, "R6");                  // latest load wins
        step(1'b0, '0, 1'b0, "R4");                    // idle hold
        if ((ci + f) % 2 == 0) begin
          while (mPhase != 3) step(1'b0, '0, 1'b1, "R4");
          step(1'b1, code, 1'b1, "R7");                // load on wrap tick
        end
        for (int k = 0; k < 9; k++) begin
          step(1'b0, '0, 1'b1, tag);
          if (k == 4) step(1'b0, '0, 1'b0, "R4");
        end
      end
    end

    // R7: wrap-tick load overrides an earlier staged code
    while (mPhase != 3) step(1'b0, '0, 1'b1, "R4");
    step(1'b1, 18'd4094, 1'b0, "R6");
    step(1'b1, 18'h3FFFF, 1'b1, "R7");
    check(16'hFFFF, "R7");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule